// File: doc/BRIEF.md
# I2C Target Address Matcher

This block sits behind the edge and start/stop detectors of an I2C target. After each start condition it watches the first byte on the bus. It compares the first seven bits, most significant bit first, with a configured 7-bit address. It takes the eighth bit as the transfer direction. It then either pulls SDA low for the acknowledge clock or leaves SDA released so that the controller sees a NACK. The surrounding target logic reads the `hit` and `miss` flags and the captured direction. It then decides whether to handle the data bytes that follow.

SDA is sampled only in cycles where the one-cycle `scl_rise` strobe is high. The acknowledge drive only changes in cycles where the delayed falling-edge strobe `scl_fall_dly` is high. As a result, the pull-down never moves while SCL is high.

The block is a state machine with these states:
- `ST_IDLE`: waits after reset for the first start pulse.
- `ST_ADDR`: shifts in and compares address bits. On a wrong bit it goes to `ST_MISS`. After the seventh good bit it goes to `ST_DIR`.
- `ST_DIR`: the next rising strobe captures the direction bit and moves to `ST_ACK_ARM`.
- `ST_ACK_ARM`: the next delayed falling strobe turns the pull-down on and moves to `ST_ACK_HOLD`.
- `ST_ACK_HOLD`: the delayed falling strobe after the acknowledge clock releases SDA, sets `hit` and moves to `ST_HIT`.
- `ST_HIT` and `ST_MISS`: terminal states that ignore all strobes.

A `start` pulse moves the machine from any state to `ST_ADDR`.

Top module: `i2c_addr_match`

## Requirements
- R1: While `rst_n` is low, and after it returns high, `hit`, `miss`, `dir_rd` and `sda_pull` are 0. Until the first `start` pulse, SCL strobes change none of them.
- R2: After a start, address bits are compared most significant bit first, one bit per `scl_rise`. `miss` goes high in the cycle after the rising strobe that carries the first bit differing from `own_addr`. It does not wait for the remaining bits.
- R3: `hit` and `miss` stay 0 until the match decision. They are never 1 at the same time.
- R4: On a match, the eighth sampled bit is presented on `dir_rd`: 1 means read and 0 means write. On a mismatch, `dir_rd` stays 0.
- R5: On a match, `sda_pull` rises in the cycle after the first `scl_fall_dly` following the eighth rising strobe. It stays high through the ninth rising strobe. It falls in the cycle after the next `scl_fall_dly`. It changes only after a delayed falling strobe, a start or a reset.
- R6: On a mismatch, `sda_pull` stays 0 for the whole byte, including the acknowledge clock.
- R7: `hit` rises in the same cycle that `sda_pull` is released after the acknowledge clock, with `miss` at 0. It is still 0 while the acknowledge is being driven.
- R8: Once `hit` or `miss` is set, further SCL strobes do not change `hit`, `miss`, `dir_rd` or `sda_pull` until the next start or reset.
- R9: A `start` pulse clears `hit`, `miss`, `dir_rd`, `sda_pull` and the bit count, and re-arms matching. It takes priority over a strobe in the same cycle, which is then ignored. A mismatching byte followed by a start and a matching byte ends with `hit` = 1 and `miss` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | One-cycle pulse on a detected start condition |
| scl_rise | input | 1 | One-cycle strobe, SCL rising edge (SDA sampled) |
| scl_fall_dly | input | 1 | One-cycle strobe, delayed SCL falling edge (ACK drive changes) |
| sda_in | input | 1 | Resolved SDA level, 1 when released |
| own_addr | input | 7 | Configured target address |
| dir_rd | output | 1 | Captured direction bit, 1 = read |
| hit | output | 1 | Address matched and acknowledged |
| miss | output | 1 | Address mismatch detected |
| sda_pull | output | 1 | Open-drain SDA pull-down enable |

## Verification
Most wrong internal states show up within one strobe.

A bit counter that is off by one compares the wrong address bit. `miss` then rises one rising strobe too early or too late in the prefix sweep.

A wrong state after the direction bit shows as a pull-down that moves one falling strobe early or late. It can also show as `hit` rising while SDA is still held.

A terminal state that is not sticky shows as flags that change under the extra strobes sent after every decision. A start that fails to clear the counter shows as a wrong decision on the very next byte.

// File: rtl/i2c_am_pkg.sv
package i2c_am_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ADDR,
        ST_DIR,
        ST_ACK_ARM,
        ST_ACK_HOLD,
        ST_HIT,
        ST_MISS
    } am_state_e;
endpackage

// File: rtl/i2c_am_bitcnt.sv
module i2c_am_bitcnt #(
    parameter int unsigned W    = 3,
    parameter int unsigned LAST = 6
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         inc,
    output logic [W-1:0] cnt,
    output logic         last
);
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            cnt <= '0;
        end else if (inc) begin
            cnt <= cnt + 1'b1;
        end
    end

    assign last = (cnt == W'(LAST));
endmodule

// File: rtl/i2c_addr_match.sv
module i2c_addr_match #(
    parameter int unsigned ADDR_W = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              scl_rise,
    input  logic              scl_fall_dly,
    input  logic              sda_in,
    input  logic [ADDR_W-1:0] own_addr,
    output logic              dir_rd,
    output logic              hit,
    output logic              miss,
    output logic              sda_pull
);
    import i2c_am_pkg::*;

    localparam int unsigned CNT_W = $clog2(ADDR_W + 1);

    am_state_e        state, state_nx;
    logic [CNT_W-1:0] bit_cnt;
    logic [CNT_W-1:0] bit_idx;
    logic             last_bit;
    logic             exp_bit;
    logic             bit_ok;
    logic             cnt_inc;

    // expected address bit, most significant first
    always_comb begin
        bit_idx = CNT_W'(ADDR_W - 1) - bit_cnt;
        exp_bit = own_addr[bit_idx];
        bit_ok  = (sda_in == exp_bit);
        cnt_inc = (state == ST_ADDR) && scl_rise && bit_ok && !start;
    end

    i2c_am_bitcnt #(
        .W    (CNT_W),
        .LAST (ADDR_W - 1)
    ) bitcnt_i (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (start),
        .inc   (cnt_inc),
        .cnt   (bit_cnt),
        .last  (last_bit)
    );

    // next-state logic
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:     state_nx = ST_IDLE;
            ST_ADDR: begin
                if (scl_rise) begin
                    if (!bit_ok)       state_nx = ST_MISS;
                    else if (last_bit) state_nx = ST_DIR;
                end
            end
            ST_DIR:      if (scl_rise)     state_nx = ST_ACK_ARM;
            ST_ACK_ARM:  if (scl_fall_dly) state_nx = ST_ACK_HOLD;
            ST_ACK_HOLD: if (scl_fall_dly) state_nx = ST_HIT;
            ST_HIT:      state_nx = ST_HIT;
            ST_MISS:     state_nx = ST_MISS;
            default:     state_nx = ST_IDLE;
        endcase
        if (start) state_nx = ST_ADDR;
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    // registered outputs
    always_ff @(posedge clk) begin
        if (!rst_n || start) begin
            dir_rd   <= 1'b0;
            hit      <= 1'b0;
            miss     <= 1'b0;
            sda_pull <= 1'b0;
        end else begin
            unique case (state)
                ST_ADDR:     if (scl_rise && !bit_ok) miss <= 1'b1;
                ST_DIR:      if (scl_rise) dir_rd <= sda_in;
                ST_ACK_ARM:  if (scl_fall_dly) sda_pull <= 1'b1;
                ST_ACK_HOLD: begin
                    if (scl_fall_dly) begin
                        sda_pull <= 1'b0;
                        hit      <= 1'b1;
                    end
                end
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/i2c_addr_match_chk.sv
module i2c_addr_match_chk (
    input logic clk,
    input logic rst_n,
    input logic start,
    input logic scl_rise,
    input logic scl_fall_dly,
    input logic dir_rd,
    input logic hit,
    input logic miss,
    input logic sda_pull
);
    p_flags_excl_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !(hit && miss));

    p_miss_on_rise_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(miss) |-> $past(scl_rise));

    p_pull_on_fall_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sda_pull) |-> $past(scl_fall_dly));

    p_pull_release_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(sda_pull) |-> ($past(scl_fall_dly) || $past(start)));

    p_no_pull_miss_r6: assert property (@(posedge clk) disable iff (!rst_n)
        miss |-> !sda_pull);

    p_hit_release_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(hit) |-> (!sda_pull && $past(sda_pull)));

    p_hit_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (hit && !start) |=> (hit && $stable(dir_rd)));

    p_miss_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (miss && !start) |=> miss);

    p_start_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> (!hit && !miss && !sda_pull && !dir_rd));
endmodule

bind i2c_addr_match i2c_addr_match_chk chk_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .start        (start),
    .scl_rise     (scl_rise),
    .scl_fall_dly (scl_fall_dly),
    .dir_rd       (dir_rd),
    .hit          (hit),
    .miss         (miss),
    .sda_pull     (sda_pull)
);

// File: tb/i2c_addr_match_tb_top.sv
`timescale 1ns/1ps
module i2c_addr_match_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start = 1'b0;
    logic       scl_rise = 1'b0;
    logic       scl_fall_dly = 1'b0;
    logic       sda_in = 1'b1;
    logic [6:0] own_addr = 7'h00;
    logic       dir_rd, hit, miss, sda_pull;

    int n_checks = 0;
    int n_errors = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    i2c_addr_match dut_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .start        (start),
        .scl_rise     (scl_rise),
        .scl_fall_dly (scl_fall_dly),
        .sda_in       (sda_in),
        .own_addr     (own_addr),
        .dir_rd       (dir_rd),
        .hit          (hit),
        .miss         (miss),
        .sda_pull     (sda_pull)
    );

    task automatic check(input string req, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_errors++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    task automatic pulse_start();
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic rise(input logic b);
        sda_in   = b;
        scl_rise = 1'b1;
        @(negedge clk);
        scl_rise = 1'b0;
        @(negedge clk);
    endtask

    task automatic fall();
        scl_fall_dly = 1'b1;
        @(negedge clk);
        scl_fall_dly = 1'b0;
        @(negedge clk);
    endtask

    task automatic run_txn(input logic [6:0] own, input logic [6:0] rx, input logic rw);
        bit match;
        match    = (own == rx);
        own_addr = own;
        pulse_start();
        check("R9 start clears hit", int'(hit), 0);
        check("R9 start clears miss", int'(miss), 0);
        for (int i = 0; i < 7; i++) begin
            rise(rx[6-i]);
            check("R2 early miss", int'(miss), int'((((rx ^ own) >> (6 - i)) != 7'd0)));
            check("R3 no hit before decision", int'(hit), 0);
            fall();
            check("R6 no pull during address", int'(sda_pull), 0);
        end
        rise(rw);
        check("R4 direction capture", int'(dir_rd), match ? int'(rw) : 0);
        fall();
        check("R5 R6 pull for ack clock", int'(sda_pull), int'(match));
        rise(match ? 1'b0 : 1'b1);
        check("R5 pull held over ninth rise", int'(sda_pull), int'(match));
        check("R7 hit low while ack driven", int'(hit), 0);
        fall();
        check("R5 pull released", int'(sda_pull), 0);
        check("R7 hit after ack", int'(hit), int'(match));
        check("R3 miss decision", int'(miss), int'(!match));
        // extra strobes after the decision must be ignored
        rise(~rw);
        fall();
        check("R8 hit held", int'(hit), int'(match));
        check("R8 miss held", int'(miss), int'(!match));
        check("R8 dir held", int'(dir_rd), match ? int'(rw) : 0);
        check("R8 pull stays off", int'(sda_pull), 0);
    endtask

    initial begin
        logic [6:0] owns [4];
        owns[0] = 7'h63; owns[1] = 7'h00; owns[2] = 7'h7F; owns[3] = 7'h2A;

        repeat (3) @(negedge clk);
        check("R1 reset hit", int'(hit), 0);
        check("R1 reset miss", int'(miss), 0);
        check("R1 reset pull", int'(sda_pull), 0);
        check("R1 reset dir", int'(dir_rd), 0);
        rst_n = 1'b1;
        @(negedge clk);
        // idle before first start: strobes with a wrong bit do nothing
        own_addr = 7'h40;
        rise(1'b0);
        fall();
        rise(1'b1);
        fall();
        check("R1 idle miss", int'(miss), 0);
        check("R1 idle pull", int'(sda_pull), 0);

        // sweep: every received address against several own addresses, both directions
        foreach (owns[k]) begin
            for (int a = 0; a < 128; a++) begin
                for (int d = 0; d < 2; d++) begin
                    run_txn(owns[k], 7'(a), 1'(d));
                end
            end
        end

        // R9: mismatch followed by match
        run_txn(7'h63, 7'h73, 1'b1);
        run_txn(7'h63, 7'h63, 1'b0);
        check("R9 match after mismatch hit", int'(hit), 1);
        check("R9 match after mismatch miss", int'(miss), 0);

        // R9: start wins over a same-cycle wrong bit, counter stays at the first bit
        own_addr = 7'h55;
        pulse_start();
        sda_in = 1'b0; scl_rise = 1'b1; start = 1'b1;
        @(negedge clk);
        scl_rise = 1'b0; start = 1'b0;
        @(negedge clk);
        check("R9 strobe ignored on start", int'(miss), 0);
        for (int i = 0; i < 7; i++) begin
            rise(own_addr[6-i]);
            fall();
        end
        rise(1'b1);
        fall();
        check("R9 counter rearmed pull", int'(sda_pull), 1);

        // R9: start during the acknowledge drive releases SDA
        pulse_start();
        check("R9 start releases pull", int'(sda_pull), 0);
        check("R9 start clears dir", int'(dir_rd), 0);

        // R1: reset mid-byte clears and returns to idle
        for (int i = 0; i < 3; i++) begin
            rise(own_addr[6-i]);
            fall();
        end
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        rise(~own_addr[3]);
        fall();
        check("R1 idle after reset miss", int'(miss), 0);
        check("R1 idle after reset hit", int'(hit), 0);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

    initial begin
        repeat (195000) @(posedge clk);
        if (!done) begin
            n_errors++;
            n_checks++;
            $display("FAIL watchdog expired");
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    end
endmodule